// File: doc/BRIEF.md
# CPU Bus Memory Map Decoder

This block sits between the 8-bit console processor and the memories and register files that share its 16-bit address space. Each cycle it looks at the address and the read and write requests. It raises exactly one select strobe for the target that owns the access. It also hands that target the address offset inside its window. Read requests go to the two cartridge ROM windows. Writes anywhere in the lower half of the map go to the cartridge bank controller.

Returned data from every target arrives on its own input bus. The decoder registers the chosen byte, so the processor sees it one cycle after it presents the address. Accesses that reach nothing read as 0xFF and have no write effect. These are the unusable hole above sprite attribute memory, and attribute memory itself while the video engine owns it (mode 2 or 3). Work RAM is also visible through a mirror window in the 0xE000 to 0xFDFF range.

Top module: `memmap_decoder`

## Requirements
- R1: `selOut` bit positions are: 0 fixed ROM, 1 banked ROM, 2 bank controller, 3 video RAM, 4 external RAM, 5 work RAM bank 0, 6 switchable work RAM, 7 attribute memory, 8 I/O, 9 high RAM, 10 interrupt enable, 11 null target. Whenever `cpuRd` or `cpuWr` is high, exactly one bit is set. When both are low, `selOut` is zero.
- R2: Reads of 0x0000-0x3FFF select bit 0 and reads of 0x4000-0x7FFF select bit 1, each with offset `cpuAddr[13:0]`. Any write to 0x0000-0x7FFF selects bit 2 with offset `cpuAddr[14:0]`.
- R3: 0x8000-0x9FFF selects bit 3 and 0xA000-0xBFFF selects bit 4, each with offset `cpuAddr[12:0]`.
- R4: 0xC000-0xCFFF and its mirror 0xE000-0xEFFF select bit 5, with offset `cpuAddr[11:0]`.
- R5: 0xD000-0xDFFF and the mirror 0xF000-0xFDFF select bit 6, with offset `cpuAddr[11:0]`.
- R6: 0xFE00-0xFE9F selects bit 7 with offset `cpuAddr[7:0]` when `vidMode` is 0 or 1.
- R7: 0xFE00-0xFE9F with `vidMode` 2 or 3 selects bit 11 only, and a read of it returns 0xFF.
- R8: 0xFEA0-0xFEFF selects bit 11 only, and a read of it returns 0xFF.
- R9: 0xFF00-0xFF7F selects bit 8 and 0xFF80-0xFFFE selects bit 9, each with offset `cpuAddr[6:0]`. 0xFFFF selects bit 10 with offset 0.
- R10: After a read is sampled on a rising edge, `rdData` equals the data input of the selected target. Without a read it keeps its value, and reset sets it to 0xFF.
- R11: When `cpuRd` and `cpuWr` are both high, the access is decoded as a write and `rdData` is not updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | Processor address |
| cpuRd | input | 1 | Read request |
| cpuWr | input | 1 | Write request |
| vidMode | input | 2 | Current video engine mode |
| selOut | output | 12 | One-hot target select |
| tgtOfs | output | 15 | Offset inside the selected window |
| romFixData | input | 8 | Fixed ROM read data |
| romBankData | input | 8 | Banked ROM read data |
| vramData | input | 8 | Video RAM read data |
| extData | input | 8 | External RAM read data |
| wram0Data | input | 8 | Work RAM bank 0 read data |
| wramNData | input | 8 | Switchable work RAM read data |
| oamData | input | 8 | Attribute memory read data |
| ioData | input | 8 | I/O register read data |
| hramData | input | 8 | High RAM read data |
| ieData | input | 8 | Interrupt enable read data |
| rdData | output | 8 | Registered read data |

## Verification
Two things can happen in the same cycle: the registered read data of one access is delivered while the select strobe of the next access is raised. The bench runs back-to-back accesses, each with its own random address, operation and video mode. In every cycle it checks the combinational strobe and offset for the current access. After the edge it checks `rdData` against the target of the previous read, or against the value that was held. Directed accesses at each window edge, and attribute memory accesses under each mode, are mixed in so that a blocked read can come right after a normal one.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  localparam int NUM_TGT = 12;
  localparam int OFS_W   = 15;

  typedef enum logic [3:0] {
    TG_ROMFIX  = 4'd0,
    TG_ROMBANK = 4'd1,
    TG_MBC     = 4'd2,
    TG_VRAM    = 4'd3,
    TG_EXT     = 4'd4,
    TG_WRAM0   = 4'd5,
    TG_WRAMN   = 4'd6,
    TG_OAM     = 4'd7,
    TG_IO      = 4'd8,
    TG_HRAM    = 4'd9,
    TG_IE      = 4'd10,
    TG_NULL    = 4'd11
  } tgt_e;

  typedef struct packed {
    logic active;
    logic load;
    tgt_e tgt;
  } busCtl_t;
endpackage

// File: rtl/memmap_ctrl.sv
module memmap_ctrl
  import memmap_pkg::*;
(
  input  logic [15:0]        cpuAddr,
  input  logic               cpuRd,
  input  logic               cpuWr,
  input  logic [1:0]         vidMode,
  output logic [NUM_TGT-1:0] selOut,
  output busCtl_t            busCtl
);
  logic isWrite;
  logic isRead;
  tgt_e hiPage;
  tgt_e tgt;

  assign isWrite = cpuWr;
  assign isRead  = cpuRd & ~cpuWr;

  always_comb begin
    if (cpuAddr < 16'hFE00)      hiPage = TG_WRAMN;
    else if (cpuAddr < 16'hFEA0) hiPage = vidMode[1] ? TG_NULL : TG_OAM;
    else if (cpuAddr < 16'hFF00) hiPage = TG_NULL;
    else if (cpuAddr < 16'hFF80) hiPage = TG_IO;
    else if (cpuAddr != 16'hFFFF) hiPage = TG_HRAM;
    else                         hiPage = TG_IE;
  end

  always_comb begin
    unique case (cpuAddr[15:12])
      4'h0, 4'h1, 4'h2, 4'h3: tgt = isWrite ? TG_MBC : TG_ROMFIX;
      4'h4, 4'h5, 4'h6, 4'h7: tgt = isWrite ? TG_MBC : TG_ROMBANK;
      4'h8, 4'h9:             tgt = TG_VRAM;
      4'hA, 4'hB:             tgt = TG_EXT;
      4'hC, 4'hE:             tgt = TG_WRAM0;
      4'hD:                   tgt = TG_WRAMN;
      default:                tgt = hiPage;
    endcase
  end

  always_comb begin
    selOut = '0;
    if (isRead | isWrite) selOut[tgt] = 1'b1;
  end

  assign busCtl.active = isRead | isWrite;
  assign busCtl.load   = isRead;
  assign busCtl.tgt    = tgt;
endmodule

// File: rtl/memmap_dpath.sv
module memmap_dpath
  import memmap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [15:0]                   cpuAddr,
  input  busCtl_t                       busCtl,
  input  logic [NUM_TGT-1:0][DATA_W-1:0] srcBus,
  output logic [OFS_W-1:0]              tgtOfs,
  output logic [DATA_W-1:0]             rdData
);
  logic [OFS_W-1:0] ofsMask;

  always_comb begin
    unique case (busCtl.tgt)
      TG_ROMFIX, TG_ROMBANK: ofsMask = 15'h3FFF;
      TG_MBC:                ofsMask = 15'h7FFF;
      TG_VRAM, TG_EXT:       ofsMask = 15'h1FFF;
      TG_WRAM0, TG_WRAMN:    ofsMask = 15'h0FFF;
      TG_OAM:                ofsMask = 15'h00FF;
      TG_IO, TG_HRAM:        ofsMask = 15'h007F;
      default:               ofsMask = '0;
    endcase
  end

  assign tgtOfs = busCtl.active ? (cpuAddr[OFS_W-1:0] & ofsMask) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)           rdData <= '1;
    else if (busCtl.load) rdData <= srcBus[busCtl.tgt];
  end
endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import memmap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [15:0]         cpuAddr,
  input  logic                cpuRd,
  input  logic                cpuWr,
  input  logic [1:0]          vidMode,
  output logic [NUM_TGT-1:0]  selOut,
  output logic [OFS_W-1:0]    tgtOfs,
  input  logic [DATA_W-1:0]   romFixData,
  input  logic [DATA_W-1:0]   romBankData,
  input  logic [DATA_W-1:0]   vramData,
  input  logic [DATA_W-1:0]   extData,
  input  logic [DATA_W-1:0]   wram0Data,
  input  logic [DATA_W-1:0]   wramNData,
  input  logic [DATA_W-1:0]   oamData,
  input  logic [DATA_W-1:0]   ioData,
  input  logic [DATA_W-1:0]   hramData,
  input  logic [DATA_W-1:0]   ieData,
  output logic [DATA_W-1:0]   rdData
);
  busCtl_t busCtl;
  logic [NUM_TGT-1:0][DATA_W-1:0] srcBus;

  assign srcBus[TG_ROMFIX]  = romFixData;
  assign srcBus[TG_ROMBANK] = romBankData;
  assign srcBus[TG_MBC]     = '1;
  assign srcBus[TG_VRAM]    = vramData;
  assign srcBus[TG_EXT]     = extData;
  assign srcBus[TG_WRAM0]   = wram0Data;
  assign srcBus[TG_WRAMN]   = wramNData;
  assign srcBus[TG_OAM]     = oamData;
  assign srcBus[TG_IO]      = ioData;
  assign srcBus[TG_HRAM]    = hramData;
  assign srcBus[TG_IE]      = ieData;
  assign srcBus[TG_NULL]    = '1;

  memmap_ctrl ctrl_i (
    .cpuAddr (cpuAddr),
    .cpuRd   (cpuRd),
    .cpuWr   (cpuWr),
    .vidMode (vidMode),
    .selOut  (selOut),
    .busCtl  (busCtl)
  );

  memmap_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpuAddr (cpuAddr),
    .busCtl  (busCtl),
    .srcBus  (srcBus),
    .tgtOfs  (tgtOfs),
    .rdData  (rdData)
  );
endmodule

// File: rtl/memmap_decoder_chk.sv
module memmap_decoder_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cpuAddr,
  input logic              cpuRd,
  input logic              cpuWr,
  input logic [1:0]        vidMode,
  input logic [11:0]       selOut,
  input logic [DATA_W-1:0] rdData
);
  logic anyAcc;
  logic inOam;
  logic inHole;
  assign anyAcc = cpuRd | cpuWr;
  assign inOam  = (cpuAddr >= 16'hFE00) && (cpuAddr < 16'hFEA0);
  assign inHole = (cpuAddr >= 16'hFEA0) && (cpuAddr < 16'hFF00);

  a_r1_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    anyAcc |-> ($countones(selOut) == 1));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !anyAcc |-> (selOut == '0));
  a_r2_rom_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuWr && !cpuAddr[15]) |-> selOut[2]);
  a_r7_oam_block: assert property (@(posedge clk) disable iff (!rst_n)
    (anyAcc && inOam && vidMode[1]) |-> (selOut[11] && !selOut[7]));
  a_r8_hole_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuRd && !cpuWr && inHole) |=> (rdData == '1));
  a_r9_ie_top: assert property (@(posedge clk) disable iff (!rst_n)
    (anyAcc && cpuAddr == 16'hFFFF) |-> selOut[10]);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpuRd || cpuWr) |=> $stable(rdData));
endmodule

bind memmap_decoder memmap_decoder_chk #(.DATA_W(DATA_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .cpuAddr (cpuAddr),
  .cpuRd   (cpuRd),
  .cpuWr   (cpuWr),
  .vidMode (vidMode),
  .selOut  (selOut),
  .rdData  (rdData)
);

// File: tb/memmap_decoder_tb.sv
module memmap_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic cpuRd = 1'b0;
  logic cpuWr = 1'b0;
  logic [1:0] vidMode = '0;
  logic [11:0] selOut;
  logic [14:0] tgtOfs;
  logic [7:0] rdData;
  int checks = 0;
  int failures = 0;
  logic [7:0] expRd;

  localparam logic [7:0] D_ROMF = 8'h10, D_ROMB = 8'h21, D_VRAM = 8'h32,
    D_EXT = 8'h43, D_W0 = 8'h54, D_WN = 8'h65, D_OAM = 8'h76, D_IO = 8'h87,
    D_HRAM = 8'h98, D_IE = 8'hA9;

  always #10 clk = ~clk;

  memmap_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .vidMode(vidMode), .selOut(selOut), .tgtOfs(tgtOfs),
    .romFixData(D_ROMF), .romBankData(D_ROMB), .vramData(D_VRAM),
    .extData(D_EXT), .wram0Data(D_W0), .wramNData(D_WN), .oamData(D_OAM),
    .ioData(D_IO), .hramData(D_HRAM), .ieData(D_IE), .rdData(rdData)
  );

  function automatic int expTgt(input logic [15:0] a, input logic wr, input logic [1:0] m);
    if (a <= 16'h3FFF) return wr ? 2 : 0;
    if (a <= 16'h7FFF) return wr ? 2 : 1;
    if (a <= 16'h9FFF) return 3;
    if (a <= 16'hBFFF) return 4;
    if (a <= 16'hCFFF) return 5;
    if (a <= 16'hDFFF) return 6;
    if (a <= 16'hEFFF) return 5;
    if (a <= 16'hFDFF) return 6;
    if (a <= 16'hFE9F) return (m >= 2) ? 11 : 7;
    if (a <= 16'hFEFF) return 11;
    if (a <= 16'hFF7F) return 8;
    if (a <= 16'hFFFE) return 9;
    return 10;
  endfunction

  function automatic logic [14:0] expOfs(input logic [15:0] a, input int t);
    case (t)
      0, 1:  return {1'b0, a[13:0]};
      2:     return a[14:0];
      3, 4:  return {2'b0, a[12:0]};
      5, 6:  return {3'b0, a[11:0]};
      7:     return {7'b0, a[7:0]};
      8, 9:  return {8'b0, a[6:0]};
      default: return '0;
    endcase
  endfunction

  function automatic logic [7:0] expData(input int t);
    case (t)
      0: return D_ROMF;  1: return D_ROMB; 3: return D_VRAM; 4: return D_EXT;
      5: return D_W0;    6: return D_WN;   7: return D_OAM;  8: return D_IO;
      9: return D_HRAM;  10: return D_IE;  default: return 8'hFF;
    endcase
  endfunction

  function automatic string reqTag(input int t, input logic [15:0] a);
    case (t)
      0, 1, 2: return "R2";
      3, 4:    return "R3";
      5:       return "R4";
      6:       return "R5";
      7:       return "R6";
      8, 9, 10: return "R9";
      default: return (a < 16'hFEA0) ? "R7" : "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic rd, input logic wr, input logic [1:0] m);
    int t;
    @(negedge clk);
    cpuAddr = a; cpuRd = rd; cpuWr = wr; vidMode = m;
    #1;
    t = expTgt(a, wr, m);
    if (rd | wr) begin
      chk({reqTag(t, a), " R1 sel"}, {20'b0, selOut}, 32'(12'(1) << t));
      chk({reqTag(t, a), " ofs"}, {17'b0, tgtOfs}, {17'b0, expOfs(a, t)});
    end else begin
      chk("R1 idle sel", {20'b0, selOut}, 32'h0);
    end
    if (rd && wr) chk("R11 both as write", {20'b0, selOut}, 32'(12'(1) << expTgt(a, 1'b1, m)));
    if (rd && !wr) expRd = expData(t);
    @(posedge clk); #1;
    chk((rd && wr) ? "R11 no load" : (rd ? {reqTag(t, a), " R10 data"} : "R10 hold"),
        {24'b0, rdData}, {24'b0, expRd});
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    expRd = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset rdData", {24'b0, rdData}, 32'hFF);
    chk("R1 reset sel", {20'b0, selOut}, 32'h0);
    rst_n = 1'b1;
    access(16'h0000, 1, 0, 0);
    access(16'h3FFF, 1, 0, 0);
    access(16'h4000, 1, 0, 0);
    access(16'h7FFF, 0, 1, 0);
    access(16'h2100, 0, 1, 0);
    access(16'h9FFF, 1, 0, 0);
    access(16'hA000, 1, 0, 0);
    access(16'hE000, 1, 0, 0);
    access(16'hEFFF, 1, 0, 0);
    access(16'hF000, 1, 0, 0);
    access(16'hFDFF, 1, 0, 0);
    access(16'hFE00, 1, 0, 1);
    access(16'hFE9F, 1, 0, 2);
    access(16'hFE10, 1, 0, 0);
    access(16'hFE10, 1, 0, 3);
    access(16'hFE50, 0, 1, 2);
    access(16'hFEA0, 1, 0, 0);
    access(16'hFEFF, 0, 1, 0);
    access(16'hFF00, 1, 0, 0);
    access(16'hFF7F, 1, 0, 0);
    access(16'hFF80, 1, 0, 0);
    access(16'hFFFE, 1, 0, 0);
    access(16'hFFFF, 1, 0, 0);
    access(16'hC123, 1, 1, 0);
    access(16'h1234, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      logic [1:0] op;
      a = 16'($urandom);
      if (i % 4 == 0) a = {8'hFE, 8'($urandom)};
      if (i % 7 == 0) a = {8'hFF, 8'($urandom)};
      op = 2'($urandom);
      access(a, op[0], op[1], 2'($urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule